// File: doc/BRIEF.md
# Host UART Link with Byte-Granular Flow Control

This block is a full-duplex serial transport between a host processor and a command engine. One shared baud generator runs from the fast system clock. It produces a tick at 16 times the bit rate, and both the receiver and the transmitter use it. Received characters go into a byte FIFO that the command engine drains with a valid/ready handshake. Bytes to transmit arrive on a valid/ready stream. Each byte carries a flag that marks it as the last byte of a message.

Flow control works on whole bytes in both directions. When the host raises CTS, the block still finishes the character it is sending. It then starts no new character until CTS falls. The block raises RTS when the FIFO fill passes a programmable threshold. It drops RTS again only after the fill has fallen a fixed margin below that threshold.

A baud-rate change request is held pending. The new divisor takes effect only after the next outgoing message has fully left the transmitter, so the acknowledge goes out at the rate the host still expects. Error events are reported as one-cycle pulses: break, idle line, framing error, parity error and FIFO overflow on the receive side, and underflow on the transmit side.

Top module: `host_uart_link`

## Requirements
- R1: After reset, txd_o is high, rts_o is low, rx_valid_o is low, and the divisor is DEF_DIV. One bit time is 16 × divisor clock cycles, and a divisor of 0 acts as 1.
- R2: The receiver accepts frames with this format: a low start bit, 8 data bits with the LSB first, one even-parity bit only when parity_en_i is 1, and a high stop bit. It accepts host bit times from 2.5% longer to 1.5% shorter than nominal. It stores the bytes in arrival order, and they are read through rx_valid_o/rx_ready_i.
- R3: Each byte taken on tx_valid_i/tx_ready_o is sent on txd_o in the same frame format. Each bit lasts one bit time, except the start bit, which may be up to one tick (one divisor period) shorter.
- R4: A character already on txd_o always completes. While the synchronized CTS is high, tx_ready_o is low and no new start bit appears.
- R5: rts_o rises when the FIFO fill exceeds rts_thresh_i. It falls when the fill plus HYST is less than rts_thresh_i.
- R6: A byte that completes while the FIFO holds DEPTH bytes is dropped, and err_overflow_o pulses. The stored bytes are left unchanged.
- R7: If a frame has a low stop bit and at least one high data or parity bit, err_frame_o pulses and the byte is not stored.
- R8: If the data bits, the parity bit and the stop bit of a frame are all low, err_break_o pulses instead of err_frame_o. No byte is stored, and the receiver waits for the line to go high before it looks for a new start bit.
- R9: If the received parity bit does not give even parity over the data, err_parity_o pulses and the byte is still stored.
- R10: After a byte is stored, rx_idle_o pulses once if the line stays high for IDLE_BITS bit times. A new start bit that arrives earlier cancels the pulse.
- R11: When a byte with tx_last_i = 0 finishes its stop bit and tx_valid_i is low in that cycle, tx_underflow_o pulses. A byte with tx_last_i = 1 never causes this pulse.
- R12: A pulse on baud_req_i captures baud_div_i as the pending divisor. The pending divisor takes effect in the cycle after the stop bit of the next transmitted byte with tx_last_i = 1 ends, so that byte goes out entirely at the old rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial data from the host |
| txd_o | output | 1 | Serial data to the host |
| cts_i | input | 1 | High tells the block to pause transmission |
| rts_o | output | 1 | High asks the host to pause transmission |
| parity_en_i | input | 1 | Adds an even-parity bit to frames in both directions |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | tx_data_i is valid |
| tx_last_i | input | 1 | The byte ends a message |
| tx_ready_o | output | 1 | The transmitter takes the byte in this cycle |
| rx_data_o | output | 8 | Oldest received byte |
| rx_valid_o | output | 1 | The FIFO holds at least one byte |
| rx_ready_i | input | 1 | Pops the oldest byte |
| rts_thresh_i | input | $clog2(DEPTH)+1 | Fill level above which RTS rises |
| baud_req_i | input | 1 | Requests a divisor change |
| baud_div_i | input | DIV_W | Requested divisor, in clock cycles per tick |
| err_break_o | output | 1 | Break pulse |
| err_frame_o | output | 1 | Framing error pulse |
| err_parity_o | output | 1 | Parity error pulse |
| err_overflow_o | output | 1 | FIFO overflow pulse |
| rx_idle_o | output | 1 | Idle line pulse |
| tx_underflow_o | output | 1 | Transmit underflow pulse |

## Verification
The assertions check the following on every cycle: the FIFO fill never goes past its depth, an overflow pulse only ever follows a full FIFO, and RTS changes only when the fill has crossed the threshold in the matching direction. They also check that a start bit never follows a cycle in which CTS was high, that a divisor change only ever follows the end of a last-flagged byte, and that a receiver waiting after a break stays put while the line is low. Other behaviours can only be shown by the bench scenarios. These include decoding at skewed host bit times, a byte that completes after CTS rises in the middle of it, and an acknowledge measured at the old bit time with the next byte at the new one. They also include the idle pulse timing, and the difference between a break and a framing error.

// File: rtl/hul_pkg.sv
package hul_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_WAIT
  } ser_state_e;

  function automatic logic maj3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction
endpackage

// File: rtl/hul_baud_gen.sv
module hul_baud_gen #(
  parameter int DIV_W   = 16,
  parameter int DEF_DIV = 136
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [DIV_W-1:0] req_div_i,
  input  logic             apply_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cur_q, pend_div_q, cnt_q, eff;
  logic             pend_q;

  assign eff = (cur_q == '0) ? DIV_W'(1) : cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q      <= DIV_W'(DEF_DIV);
      pend_div_q <= '0;
      pend_q     <= 1'b0;
      cnt_q      <= '0;
      tick_o     <= 1'b0;
    end else begin
      if (cnt_q >= eff - DIV_W'(1)) begin
        cnt_q  <= '0;
        tick_o <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + DIV_W'(1);
        tick_o <= 1'b0;
      end
      if (apply_i && pend_q) begin
        cur_q  <= pend_div_q;
        pend_q <= 1'b0;
      end
      // a request in the same cycle as an apply becomes the next pending one
      if (req_i) begin
        pend_q     <= 1'b1;
        pend_div_q <= req_div_i;
      end
    end
  end

  a_r12_div_change_on_apply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q != $past(cur_q)) |-> $past(apply_i && pend_q));
endmodule

// File: rtl/hul_rx.sv
module hul_rx
  import hul_pkg::*;
#(
  parameter int IDLE_BITS = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic       par_en_i,
  output logic [7:0] byte_o,
  output logic       byte_vld_o,
  output logic       err_frame_o,
  output logic       err_break_o,
  output logic       err_parity_o,
  output logic       idle_o
);
  localparam int IDLE_TICKS = IDLE_BITS * 16;
  localparam int ICW        = $clog2(IDLE_TICKS + 1);

  ser_state_e     state_q;
  logic           rx_meta, rx_s;
  logic [3:0]     tcnt_q;
  logic [2:0]     bidx_q, samp_q;
  logic [7:0]     shift_q;
  logic           par_q, par_seen_q, any_high_q, armed_q;
  logic [ICW-1:0] idle_cnt_q;
  logic           bit_now, stop_now;

  assign bit_now  = maj3(samp_q);
  assign stop_now = maj3({samp_q[1:0], rx_s});
  assign byte_o   = shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_meta <= 1'b1;
      rx_s    <= 1'b1;
    end else begin
      rx_meta <= rxd_i;
      rx_s    <= rx_meta;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      tcnt_q       <= '0;
      bidx_q       <= '0;
      samp_q       <= '0;
      shift_q      <= '0;
      par_q        <= 1'b0;
      par_seen_q   <= 1'b0;
      any_high_q   <= 1'b0;
      armed_q      <= 1'b0;
      idle_cnt_q   <= '0;
      byte_vld_o   <= 1'b0;
      err_frame_o  <= 1'b0;
      err_break_o  <= 1'b0;
      err_parity_o <= 1'b0;
      idle_o       <= 1'b0;
    end else begin
      byte_vld_o   <= 1'b0;
      err_frame_o  <= 1'b0;
      err_break_o  <= 1'b0;
      err_parity_o <= 1'b0;
      idle_o       <= 1'b0;
      if (tick_i) begin
        case (state_q)
          ST_IDLE: begin
            if (!rx_s) begin
              state_q    <= ST_START;
              tcnt_q     <= '0;
              idle_cnt_q <= '0;
            end else if (armed_q) begin
              if (idle_cnt_q == ICW'(IDLE_TICKS - 1)) begin
                idle_o     <= 1'b1;
                armed_q    <= 1'b0;
                idle_cnt_q <= '0;
              end else begin
                idle_cnt_q <= idle_cnt_q + ICW'(1);
              end
            end
          end
          ST_WAIT: if (rx_s) state_q <= ST_IDLE;
          default: begin
            tcnt_q <= tcnt_q + 4'd1;
            if (tcnt_q >= 4'd7 && tcnt_q <= 4'd9) samp_q <= {samp_q[1:0], rx_s};
            if (state_q == ST_STOP && tcnt_q == 4'd9) begin
              // stop decided at mid-bit so a fast host's next start is not missed
              if (stop_now) begin
                byte_vld_o   <= 1'b1;
                err_parity_o <= par_seen_q && (par_q != ^shift_q);
                armed_q      <= 1'b1;
                idle_cnt_q   <= '0;
                state_q      <= ST_IDLE;
              end else begin
                err_break_o <= !any_high_q;
                err_frame_o <= any_high_q;
                state_q     <= ST_WAIT;
              end
            end else if (tcnt_q == 4'd15) begin
              case (state_q)
                ST_START: begin
                  if (bit_now) state_q <= ST_IDLE;
                  else begin
                    state_q    <= ST_DATA;
                    bidx_q     <= '0;
                    any_high_q <= 1'b0;
                    par_seen_q <= 1'b0;
                  end
                end
                ST_DATA: begin
                  shift_q    <= {bit_now, shift_q[7:1]};
                  any_high_q <= any_high_q | bit_now;
                  bidx_q     <= bidx_q + 3'd1;
                  if (bidx_q == 3'd7) state_q <= par_en_i ? ST_PAR : ST_STOP;
                end
                ST_PAR: begin
                  par_q      <= bit_now;
                  par_seen_q <= 1'b1;
                  any_high_q <= any_high_q | bit_now;
                  state_q    <= ST_STOP;
                end
                default: state_q <= ST_IDLE;
              endcase
            end
          end
        endcase
      end
    end
  end

  a_r8_wait_until_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !rx_s) |=> (state_q == ST_WAIT));
  a_r10_idle_on_high_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> $past(rx_s));
endmodule

// File: rtl/hul_tx.sv
module hul_tx
  import hul_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       cts_i,
  input  logic       par_en_i,
  input  logic [7:0] data_i,
  input  logic       valid_i,
  input  logic       last_i,
  output logic       ready_o,
  output logic       txd_o,
  output logic       underflow_o,
  output logic       last_done_o
);
  ser_state_e state_q;
  logic       cts_meta, cts_s;
  logic [3:0] tcnt_q;
  logic [2:0] bidx_q;
  logic [7:0] shift_q;
  logic       par_q, last_q;

  assign ready_o = (state_q == ST_IDLE) && !cts_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cts_meta <= 1'b0;
      cts_s    <= 1'b0;
    end else begin
      cts_meta <= cts_i;
      cts_s    <= cts_meta;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      tcnt_q      <= '0;
      bidx_q      <= '0;
      shift_q     <= '0;
      par_q       <= 1'b0;
      last_q      <= 1'b0;
      txd_o       <= 1'b1;
      underflow_o <= 1'b0;
      last_done_o <= 1'b0;
    end else begin
      underflow_o <= 1'b0;
      last_done_o <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (valid_i && ready_o) begin
          shift_q <= data_i;
          par_q   <= ^data_i;
          last_q  <= last_i;
          tcnt_q  <= '0;
          txd_o   <= 1'b0;
          state_q <= ST_START;
        end
      end else if (tick_i) begin
        tcnt_q <= tcnt_q + 4'd1;
        if (tcnt_q == 4'd15) begin
          case (state_q)
            ST_START: begin
              txd_o   <= shift_q[0];
              bidx_q  <= '0;
              state_q <= ST_DATA;
            end
            ST_DATA: begin
              bidx_q <= bidx_q + 3'd1;
              if (bidx_q == 3'd7) begin
                txd_o   <= par_en_i ? par_q : 1'b1;
                state_q <= par_en_i ? ST_PAR : ST_STOP;
              end else begin
                shift_q <= shift_q >> 1;
                txd_o   <= shift_q[1];
              end
            end
            ST_PAR: begin
              txd_o   <= 1'b1;
              state_q <= ST_STOP;
            end
            default: begin
              txd_o       <= 1'b1;
              last_done_o <= last_q;
              underflow_o <= !last_q && !valid_i;
              state_q     <= ST_IDLE;
            end
          endcase
        end
      end
    end
  end

  a_r4_line_high_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> txd_o);
  a_r4_start_needs_cts_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && $past(state_q) == ST_IDLE) |-> !$past(cts_s));
endmodule

// File: rtl/hul_fifo.sv
module hul_fifo #(
  parameter int DEPTH = 256,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic          valid_o,
  output logic [CW-1:0] count_o,
  output logic          ovf_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          full, pop_ok, push_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign pop_ok  = pop_i && valid_o;
  assign push_ok = push_i && (!full || pop_ok);
  assign data_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_o <= 1'b0;
    end else begin
      ovf_o <= push_i && !push_ok;
      if (push_ok) wr_q <= wr_q + AW'(1);
      if (pop_ok)  rd_q <= rd_q + AW'(1);
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + CW'(1);
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - CW'(1);
    end
  end

  a_r6_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  a_r6_overflow_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> ($past(cnt_q) == CW'(DEPTH)));
endmodule

// File: rtl/host_uart_link.sv
module host_uart_link #(
  parameter int DEPTH     = 256,
  parameter int DIV_W     = 16,
  parameter int DEF_DIV   = 136,
  parameter int HYST      = 16,
  parameter int IDLE_BITS = 20,
  localparam int CW       = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rxd_i,
  output logic             txd_o,
  input  logic             cts_i,
  output logic             rts_o,
  input  logic             parity_en_i,
  input  logic [7:0]       tx_data_i,
  input  logic             tx_valid_i,
  input  logic             tx_last_i,
  output logic             tx_ready_o,
  output logic [7:0]       rx_data_o,
  output logic             rx_valid_o,
  input  logic             rx_ready_i,
  input  logic [CW-1:0]    rts_thresh_i,
  input  logic             baud_req_i,
  input  logic [DIV_W-1:0] baud_div_i,
  output logic             err_break_o,
  output logic             err_frame_o,
  output logic             err_parity_o,
  output logic             err_overflow_o,
  output logic             rx_idle_o,
  output logic             tx_underflow_o
);
  logic          tick, last_done, rx_vld;
  logic [7:0]    rx_byte;
  logic [CW-1:0] fill;
  logic [CW:0]   fill_x, thr_x;

  hul_baud_gen #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_baud (
    .clk_i, .rst_ni,
    .req_i(baud_req_i), .req_div_i(baud_div_i), .apply_i(last_done), .tick_o(tick)
  );

  hul_rx #(.IDLE_BITS(IDLE_BITS)) u_rx (
    .clk_i, .rst_ni, .tick_i(tick), .rxd_i, .par_en_i(parity_en_i),
    .byte_o(rx_byte), .byte_vld_o(rx_vld),
    .err_frame_o, .err_break_o, .err_parity_o, .idle_o(rx_idle_o)
  );

  hul_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk_i, .rst_ni, .push_i(rx_vld), .data_i(rx_byte), .pop_i(rx_ready_i),
    .data_o(rx_data_o), .valid_o(rx_valid_o), .count_o(fill), .ovf_o(err_overflow_o)
  );

  hul_tx u_tx (
    .clk_i, .rst_ni, .tick_i(tick), .cts_i, .par_en_i(parity_en_i),
    .data_i(tx_data_i), .valid_i(tx_valid_i), .last_i(tx_last_i), .ready_o(tx_ready_o),
    .txd_o, .underflow_o(tx_underflow_o), .last_done_o(last_done)
  );

  assign fill_x = {1'b0, fill};
  assign thr_x  = {1'b0, rts_thresh_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rts_o <= 1'b0;
    else if (!rts_o && fill_x > thr_x) rts_o <= 1'b1;
    else if (rts_o && (fill_x + (CW+1)'(HYST)) < thr_x) rts_o <= 1'b0;
  end

  a_r5_rts_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rts_o) |-> ($past(fill_x) > $past(thr_x)));
  a_r5_rts_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rts_o) |-> (($past(fill_x) + (CW+1)'(HYST)) < $past(thr_x)));
endmodule

// File: tb/host_uart_link_tb.sv
`timescale 1ns/1ps
module host_uart_link_tb;
  localparam int DEPTH_T = 16;
  localparam int CW_T    = $clog2(DEPTH_T) + 1;
  localparam int P       = 64;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic rxd_i = 1'b1, cts_i = 1'b0, parity_en_i = 1'b0;
  logic [7:0] tx_data_i = '0;
  logic tx_valid_i = 1'b0, tx_last_i = 1'b0, rx_ready_i = 1'b0;
  logic [CW_T-1:0] rts_thresh_i = CW_T'(10);
  logic baud_req_i = 1'b0;
  logic [15:0] baud_div_i = '0;
  logic txd_o, rts_o, tx_ready_o, rx_valid_o;
  logic [7:0] rx_data_o;
  logic err_break_o, err_frame_o, err_parity_o, err_overflow_o, rx_idle_o, tx_underflow_o;

  always #2 clk = ~clk;

  host_uart_link #(.DEPTH(DEPTH_T), .DIV_W(16), .DEF_DIV(4), .HYST(4), .IDLE_BITS(20)) u_dut (
    .clk_i(clk), .rst_ni, .rxd_i, .txd_o, .cts_i, .rts_o, .parity_en_i,
    .tx_data_i, .tx_valid_i, .tx_last_i, .tx_ready_o,
    .rx_data_o, .rx_valid_o, .rx_ready_i, .rts_thresh_i, .baud_req_i, .baud_div_i,
    .err_break_o, .err_frame_o, .err_parity_o, .err_overflow_o, .rx_idle_o, .tx_underflow_o
  );

  int n_chk = 0, n_fail = 0;
  int c_brk = 0, c_frm = 0, c_par = 0, c_ovf = 0, c_idle = 0, c_und = 0;
  int mon_per = P, mon_bad = 0;
  bit mon_par = 1'b0;
  logic [7:0] mon_q[$];

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input string what, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  always @(negedge clk) if (rst_ni) begin
    if (err_break_o)    c_brk++;
    if (err_frame_o)    c_frm++;
    if (err_parity_o)   c_par++;
    if (err_overflow_o) c_ovf++;
    if (rx_idle_o)      c_idle++;
    if (tx_underflow_o) c_und++;
  end

  // decodes txd_o at the bit time the bench expects
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni && txd_o == 1'b0) begin
        automatic int p = mon_per;
        automatic logic [7:0] d = '0;
        automatic logic pb = 1'b0;
        repeat (p / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (p) @(negedge clk);
          d[i] = txd_o;
        end
        if (mon_par) begin
          repeat (p) @(negedge clk);
          pb = txd_o;
          if (pb != ^d) mon_bad++;
        end
        repeat (p) @(negedge clk);
        if (txd_o != 1'b1) mon_bad++;
        mon_q.push_back(d);
        while (txd_o == 1'b0) @(negedge clk);
      end
    end
  end

  task automatic host_send(input logic [7:0] d, input int per, input bit par,
                           input bit bad_par, input bit stop);
    rxd_i = 1'b0;
    repeat (per) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd_i = d[i];
      repeat (per) @(negedge clk);
    end
    if (par) begin
      rxd_i = (^d) ^ bad_par;
      repeat (per) @(negedge clk);
    end
    rxd_i = stop;
    repeat (per) @(negedge clk);
    rxd_i = 1'b1;
  endtask

  task automatic tx_send(input logic [7:0] d, input bit last);
    tx_data_i  = d;
    tx_last_i  = last;
    tx_valid_i = 1'b1;
    while (!tx_ready_o) @(negedge clk);
    @(negedge clk);
    tx_valid_i = 1'b0;
  endtask

  task automatic pop_byte(output logic [7:0] d, output bit ok);
    ok = rx_valid_o;
    d  = rx_data_o;
    if (ok) begin
      rx_ready_i = 1'b1;
      @(negedge clk);
      rx_ready_i = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic wait_mon(input int n);
    for (int k = 0; k < 20000 && mon_q.size() < n; k++) @(negedge clk);
  endtask

  task automatic measure_low(output int n);
    n = 0;
    while (txd_o) @(negedge clk);
    while (!txd_o) begin
      @(negedge clk);
      n++;
    end
  endtask

  bit done = 1'b0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp_q[$];
    logic [7:0] d;
    bit ok;
    int n, base, lows, c0, c1;
    bit par_sel[12];
    void'($urandom(32'd1234));

    repeat (10) @(negedge clk);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1", "txd_o", txd_o, 1);
    chk("R1", "rts_o", rts_o, 0);
    chk("R1", "rx_valid_o", rx_valid_o, 0);
    chk("R1", "tx_ready_o", tx_ready_o, 1);

    // R1/R3 default bit time: 0x00 holds the line low for start + 8 bits
    fork
      measure_low(n);
      tx_send(8'h00, 1'b1);
    join
    chk_rng("R1", "low run at default divisor", n, 9*P - 4, 9*P);
    wait_mon(1);
    chk("R3", "byte 0x00 decoded", (mon_q.size() == 1) ? int'(mon_q.pop_front()) : -1, 0);

    // R3 random transmit, without and with parity
    for (int m = 0; m < 2; m++) begin
      parity_en_i = m[0];
      mon_par     = m[0];
      exp_q.delete();
      for (int i = 0; i < 4; i++) begin
        d = 8'($urandom);
        exp_q.push_back(d);
        tx_send(d, 1'b1);
      end
      wait_mon(4);
      for (int i = 0; i < 4; i++)
        chk("R3", "transmitted byte", (mon_q.size() > 0) ? int'(mon_q.pop_front()) : -1, int'(exp_q[i]));
    end
    chk("R3", "frame errors seen on txd_o", mon_bad, 0);
    parity_en_i = 1'b0;
    mon_par     = 1'b0;
    repeat (20) @(negedge clk);

    // R2 random receive at skewed host bit times, back to back
    exp_q.delete();
    for (int i = 0; i < 12; i++) begin
      automatic int per;
      case ($urandom_range(2, 0))
        0:       per = 63;
        1:       per = 64;
        default: per = 65;
      endcase
      par_sel[i]  = 1'($urandom);
      parity_en_i = par_sel[i];
      d = 8'($urandom);
      exp_q.push_back(d);
      host_send(d, per, par_sel[i], 1'b0, 1'b1);
    end
    parity_en_i = 1'b0;
    for (int i = 0; i < 12; i++) begin
      pop_byte(d, ok);
      chk("R2", "received byte", ok ? int'(d) : -1, int'(exp_q[i]));
    end
    chk("R2", "no parity errors", c_par, 0);
    chk("R2", "no framing errors", c_frm, 0);

    // R10 idle pulse: none mid-stream, one after IDLE_BITS bit times
    repeat (12 * P) @(negedge clk);
    chk("R10", "idle pulses before timeout", c_idle, 0);
    repeat (13 * P) @(negedge clk);
    chk("R10", "idle pulses after timeout", c_idle, 1);

    // R9 parity error still stores the byte
    parity_en_i = 1'b1;
    host_send(8'h96, P, 1'b1, 1'b1, 1'b1);
    repeat (4) @(negedge clk);
    chk("R9", "parity error pulses", c_par, 1);
    pop_byte(d, ok);
    chk("R9", "byte kept despite parity error", ok ? int'(d) : -1, 8'h96);
    parity_en_i = 1'b0;

    // R7 framing error
    host_send(8'h5A, P, 1'b0, 1'b0, 1'b0);
    repeat (2 * P) @(negedge clk);
    chk("R7", "framing error pulses", c_frm, 1);
    chk("R7", "no byte stored", rx_valid_o, 0);

    // R8 break: all low, line held low further
    rxd_i = 1'b0;
    repeat (13 * P) @(negedge clk);
    rxd_i = 1'b1;
    repeat (2 * P) @(negedge clk);
    chk("R8", "break pulses", c_brk, 1);
    chk("R8", "no framing pulse for break", c_frm, 1);
    chk("R8", "no byte stored", rx_valid_o, 0);
    host_send(8'h3C, P, 1'b0, 1'b0, 1'b1);
    pop_byte(d, ok);
    chk("R8", "receiver recovers after break", ok ? int'(d) : -1, 8'h3C);

    // R5/R6 threshold 10, hysteresis 4, depth 16
    exp_q.delete();
    for (int i = 1; i <= 17; i++) begin
      d = 8'($urandom);
      if (i <= 16) exp_q.push_back(d);
      host_send(d, P, 1'b0, 1'b0, 1'b1);
      repeat (2) @(negedge clk);
      if (i == 10) chk("R5", "rts at fill 10", rts_o, 0);
      if (i == 11) chk("R5", "rts at fill 11", rts_o, 1);
    end
    chk("R6", "overflow pulses", c_ovf, 1);
    chk("R5", "rts stays high when full", rts_o, 1);
    for (int i = 0; i < 16; i++) begin
      pop_byte(d, ok);
      chk("R6", "stored byte after overflow", ok ? int'(d) : -1, int'(exp_q[i]));
      if (i == 9)  chk("R5", "rts at fill 6", rts_o, 1);
      if (i == 10) chk("R5", "rts at fill 5", rts_o, 0);
    end

    // R4 CTS raised mid-byte: byte completes, next waits
    base = mon_q.size();
    fork
      begin
        tx_send(8'hA5, 1'b1);
        tx_send(8'h5A, 1'b1);
      end
    join_none
    while (txd_o) @(negedge clk);
    repeat (3 * P) @(negedge clk);
    cts_i = 1'b1;
    wait_mon(base + 1);
    chk("R4", "byte in flight completes", (mon_q.size() > base) ? int'(mon_q[base]) : -1, 8'hA5);
    lows = 0;
    for (int i = 0; i < 4 * P; i++) begin
      @(negedge clk);
      if (!txd_o) lows++;
    end
    chk("R4", "low cycles while CTS high", lows, 0);
    chk("R4", "tx_ready_o while CTS high", tx_ready_o, 0);
    cts_i = 1'b0;
    wait_mon(base + 2);
    chk("R4", "held byte sent after CTS low", (mon_q.size() > base + 1) ? int'(mon_q[base + 1]) : -1, 8'h5A);
    mon_q.delete();
    repeat (20) @(negedge clk);

    // R11 underflow
    c0 = c_und;
    tx_send(8'h11, 1'b0);
    wait_mon(1);
    repeat (P) @(negedge clk);
    chk("R11", "underflow after non-last byte", c_und - c0, 1);
    tx_send(8'h22, 1'b1);
    wait_mon(2);
    repeat (P) @(negedge clk);
    chk("R11", "no underflow after last byte", c_und - c0, 1);
    mon_q.delete();

    // R12 deferred baud switch to divisor 2
    baud_div_i = 16'd2;
    baud_req_i = 1'b1;
    @(negedge clk);
    baud_req_i = 1'b0;
    fork measure_low(n); tx_send(8'h00, 1'b0); join
    chk_rng("R12", "non-last byte at old rate", n, 9*P - 4, 9*P);
    wait_mon(1);
    repeat (P) @(negedge clk);
    fork measure_low(n); tx_send(8'h00, 1'b1); join
    chk_rng("R12", "acknowledge at old rate", n, 9*P - 4, 9*P);
    wait_mon(2);
    repeat (P) @(negedge clk);
    mon_per = P / 2;
    fork measure_low(n); tx_send(8'h00, 1'b1); join
    chk_rng("R12", "next byte at new rate", n, 9*(P/2) - 2, 9*(P/2));
    wait_mon(3);
    repeat (P) @(negedge clk);
    tx_send(8'hC3, 1'b1);
    wait_mon(4);
    chk("R12", "byte decoded at new rate", (mon_q.size() == 4) ? int'(mon_q[3]) : -1, 8'hC3);
    c1 = c_frm;
    host_send(8'h7E, P / 2, 1'b0, 1'b0, 1'b1);
    pop_byte(d, ok);
    chk("R12", "receive at new rate", ok ? int'(d) : -1, 8'h7E);
    chk("R12", "no framing error at new rate", c_frm - c1, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule